// File: doc/BRIEF.md
# Ripple-Slice Integer ALU with Signed Compare

The block is an integer arithmetic and logic unit built from a chain of one-bit slices joined by a ripple carry. It computes bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than. A 3-bit operation word selects the function. The upper bit of that word does two jobs: it inverts operand B, and it supplies the carry into the lowest slice. Subtraction is therefore A plus the complement of B plus one.

The set-on-less-than result comes from the top slice. That slice XORs its sum bit with the signed overflow, so the answer stays correct even when the internal subtraction overflows. The resulting bit is routed to the compare input of slice 0. All other slices have their compare input tied low, so the result is 0 or 1.

All four outputs are registered once, so they reflect the operands and operation word captured at the previous rising clock edge. The reset is synchronous and active-high.

Top module: `ripple_alu_top`

## Requirements
- R1: Operation 3'b000 gives result = A AND B, one cycle after the inputs are captured.
- R2: Operation 3'b001 gives result = A OR B.
- R3: Operation 3'b010 gives result = (A + B) mod 2^WIDTH. Carry-out is the bit that leaves the top slice.
- R4: Operation 3'b110 gives result = (A - B) mod 2^WIDTH, computed as A + ~B + 1. Carry-out is 1 exactly when A >= B as unsigned numbers.
- R5: Operation 3'b111 gives result = 1 when A < B as signed two's-complement values, and 0 otherwise. This includes operand pairs whose difference overflows. Bits 1 and up are always 0.
- R6: The zero flag is 1 exactly when every bit of the registered result is 0.
- R7: The overflow flag equals the carry into the top slice XOR the carry out of it. For add, it is 1 when the operands share a sign and the sum's sign differs. For subtract and set-on-less-than, it is 1 when the operands differ in sign and the difference's sign differs from A.
- R8: For set-on-less-than, carry-out and overflow both report the internal subtraction A + ~B + 1.
- R9: A cycle with reset high clears the result to 0, sets the zero flag to 1, and clears overflow and carry-out, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation word: bit 2 negates B and feeds carry-in; bits 1:0 pick AND, OR, sum, compare |
| result_o | output | WIDTH | Registered result |
| zero_o | output | 1 | Registered all-zero flag |
| ovf_o | output | 1 | Registered signed overflow |
| cout_o | output | 1 | Registered carry out of the top slice |

## Verification
The checker assumes that the operation word holds one of the five defined codes at any edge it reasons about. The codes 011, 100 and 101 are not given a meaning.

Each property compares registered outputs with the inputs sampled one edge earlier. A property is only applied after a cycle that was not in reset.

The stimulus only ever drives the five defined codes. Inputs change on the falling edge, so every captured value is stable. The sweep covers every operand pair of a 4-bit instance, including all the signed-limit overflows. A 32-bit instance gets the signed and unsigned limit values crossed with each other, plus pseudo-random pairs.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  localparam logic [1:0] PICK_AND  = 2'd0;
  localparam logic [1:0] PICK_OR   = 2'd1;
  localparam logic [1:0] PICK_SUM  = 2'd2;
  localparam logic [1:0] PICK_LESS = 2'd3;

  // Four-way result choice shared by every slice
  function automatic logic slice_pick(input logic [1:0] pick, input logic and_v,
                                      input logic or_v, input logic sum_v,
                                      input logic less_v);
    case (pick)
      PICK_AND: return and_v;
      PICK_OR:  return or_v;
      PICK_SUM: return sum_v;
      default:  return less_v;
    endcase
  endfunction

endpackage

// File: rtl/ripple_alu_slice.sv
module ripple_alu_slice
  import ripple_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       neg_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] pick_i,
  output logic       res_o,
  output logic       cout_o
);
  logic b_eff;
  logic sum_v;

  always_comb begin
    b_eff  = b_i ^ neg_i;
    sum_v  = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    res_o  = slice_pick(pick_i, a_i & b_eff, a_i | b_eff, sum_v, less_i);
  end
endmodule

// File: rtl/ripple_alu_msb_slice.sv
module ripple_alu_msb_slice
  import ripple_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       neg_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] pick_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       ovf_o,
  output logic       set_o
);
  logic b_eff;
  logic sum_v;
  logic carry;

  always_comb begin
    b_eff  = b_i ^ neg_i;
    sum_v  = a_i ^ b_eff ^ cin_i;
    carry  = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    cout_o = carry;
    ovf_o  = cin_i ^ carry;
    set_o  = sum_v ^ (cin_i ^ carry);
    res_o  = slice_pick(pick_i, a_i & b_eff, a_i | b_eff, sum_v, less_i);
  end
endmodule

// File: rtl/ripple_alu_core.sv
module ripple_alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  logic       neg;
  logic [1:0] pick;
  logic       set_bit;

  assign neg  = op_i[2];
  assign pick = op_i[1:0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic c_in;
    logic c_out;
    logic less;

    if (i == 0) begin : g_first
      assign c_in = neg;
      assign less = set_bit;
    end else begin : g_rest
      assign c_in = g_bit[i-1].c_out;
      assign less = 1'b0;
    end

    if (i == MSB) begin : g_top
      ripple_alu_msb_slice slice_i (
        .a_i(a_i[i]), .b_i(b_i[i]), .neg_i(neg), .cin_i(c_in),
        .less_i(less), .pick_i(pick), .res_o(res_o[i]),
        .cout_o(c_out), .ovf_o(ovf_o), .set_o(set_bit)
      );
      assign cout_o = c_out;
    end else begin : g_low
      ripple_alu_slice slice_i (
        .a_i(a_i[i]), .b_i(b_i[i]), .neg_i(neg), .cin_i(c_in),
        .less_i(less), .pick_i(pick), .res_o(res_o[i]),
        .cout_o(c_out)
      );
    end
  end

  assign zero_o = ~|res_o;
endmodule

// File: rtl/ripple_alu_top.sv
module ripple_alu_top #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] res_c;
  logic             zero_c;
  logic             ovf_c;
  logic             cout_c;

  ripple_alu_core #(.WIDTH(WIDTH)) core_i (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .res_o(res_c), .zero_o(zero_c), .ovf_o(ovf_c), .cout_o(cout_c)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
      cout_o   <= 1'b0;
    end else begin
      result_o <= res_c;
      zero_o   <= zero_c;
      ovf_o    <= ovf_c;
      cout_o   <= cout_c;
    end
  end
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    zero_o == (result_o == '0)); // R6

  AST_AND_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_AND) |-> result_o == ($past(a_i) & $past(b_i))); // R1

  AST_SLT_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_SLT) |-> result_o[MSB:1] == '0); // R5

  AST_ADD_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_ADD) |->
      ovf_o == (($past(a_i[MSB]) == $past(b_i[MSB])) && (result_o[MSB] != $past(a_i[MSB])))); // R7

  AST_SUB_CARRY: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == OP_SUB) |-> cout_o == ($past(a_i) >= $past(b_i))); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    $past(rst_i) |-> (result_o == '0 && zero_o && !ovf_o && !cout_o)); // R9
endmodule

bind ripple_alu_top ripple_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o), .cout_o(cout_o)
);

// File: tb/ripple_alu_tb_top.sv
module ripple_alu_tb_top;
  localparam int WB = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WB-1:0] a_big = '0, b_big = '0;
  logic [WS-1:0] a_sm = '0, b_sm = '0;
  logic [2:0] op = 3'b000;

  logic [WB-1:0] res_big;
  logic zero_big, ovf_big, cout_big;
  logic [WS-1:0] res_sm;
  logic zero_sm, ovf_sm, cout_sm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ripple_alu_top #(.WIDTH(WB)) dut_i (
    .clk_i(clk), .rst_i(rst), .a_i(a_big), .b_i(b_big), .op_i(op),
    .result_o(res_big), .zero_o(zero_big), .ovf_o(ovf_big), .cout_o(cout_big)
  );

  ripple_alu_top #(.WIDTH(WS)) dut_nib_i (
    .clk_i(clk), .rst_i(rst), .a_i(a_sm), .b_i(b_sm), .op_i(op),
    .result_o(res_sm), .zero_o(zero_sm), .ovf_o(ovf_sm), .cout_o(cout_sm)
  );

  localparam logic [2:0] OPS [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference arithmetic on 64-bit integers
  task automatic ref_model(input int w, input logic [63:0] a, input logic [63:0] b,
                           input logic [2:0] o, output logic [63:0] res,
                           output logic zf, output logic vf, output logic cf);
    logic [63:0] mask, s, sgn;
    longint sa, sb;
    mask = (64'd1 << w) - 1;
    sgn  = 64'd1 << (w - 1);
    sa = ((a & sgn) != 0) ? longint'(a) - longint'(64'd1 << w) : longint'(a);
    sb = ((b & sgn) != 0) ? longint'(b) - longint'(64'd1 << w) : longint'(b);
    if (o[2]) s = a + ((~b) & mask) + 64'd1;
    else      s = a + b;
    cf = s[w];
    if (o[2]) vf = (((a ^ b) & sgn) != 0) && (((a ^ s) & sgn) != 0);
    else      vf = (((a ^ b) & sgn) == 0) && (((a ^ s) & sgn) != 0);
    case (o)
      3'b000:  res = a & b;
      3'b001:  res = a | b;
      3'b111:  res = (sa < sb) ? 64'd1 : 64'd0;
      default: res = s & mask;
    endcase
    zf = (res == 0);
  endtask

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare_out(input int w, input logic [63:0] a, input logic [63:0] b,
                             input logic [2:0] o, input logic [63:0] r,
                             input logic z, input logic v, input logic c);
    logic [63:0] er;
    logic ez, ev, ec;
    ref_model(w, a, b, o, er, ez, ev, ec);
    chk(op_tag(o), r, er);
    chk("R6 zero", {63'd0, z}, {63'd0, ez});
    if (o == 3'b010 || o == 3'b110) begin
      chk("R7 overflow", {63'd0, v}, {63'd0, ev});
      chk(o[2] ? "R4 carry" : "R3 carry", {63'd0, c}, {63'd0, ec});
    end else if (o == 3'b111) begin
      chk("R8 overflow", {63'd0, v}, {63'd0, ev});
      chk("R8 carry", {63'd0, c}, {63'd0, ec});
    end
  endtask

  task automatic step_big(input logic [WB-1:0] a, input logic [WB-1:0] b, input logic [2:0] o);
    @(negedge clk);
    a_big = a; b_big = b; op = o;
    @(posedge clk); #1;
    compare_out(WB, {32'd0, a}, {32'd0, b}, o, {32'd0, res_big}, zero_big, ovf_big, cout_big);
  endtask

  task automatic step_sm(input logic [WS-1:0] a, input logic [WS-1:0] b, input logic [2:0] o);
    @(negedge clk);
    a_sm = a; b_sm = b; op = o;
    @(posedge clk); #1;
    compare_out(WS, {60'd0, a}, {60'd0, b}, o, {60'd0, res_sm}, zero_sm, ovf_sm, cout_sm);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  localparam logic [WB-1:0] EDGE [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
    32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE, 32'h1234_5678};

  initial begin
    logic [31:0] lfsr;
    a_big = 32'hDEAD_BEEF; b_big = 32'h1234_5678; a_sm = 4'hF; b_sm = 4'h3; op = 3'b010;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state with nonzero inputs applied
    chk("R9 result", {32'd0, res_big}, 64'd0);
    chk("R9 zero", {63'd0, zero_big}, 64'd1);
    chk("R9 flags", {62'd0, ovf_big, cout_big}, 64'd0);
    chk("R9 nib result", {60'd0, res_sm}, 64'd0);
    @(negedge clk); rst = 1'b0;

    // Exhaustive 4-bit sweep: R1..R8
    for (int oi = 0; oi < 5; oi++)
      for (int ai = 0; ai < 16; ai++)
        for (int bi = 0; bi < 16; bi++)
          step_sm(ai[WS-1:0], bi[WS-1:0], OPS[oi]);

    // 32-bit limit crosses
    for (int oi = 0; oi < 5; oi++)
      for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++)
          step_big(EDGE[ai], EDGE[bi], OPS[oi]);

    // 32-bit pseudo-random
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step_big(ra, lfsr, OPS[k % 5]);
    end

    // R9 mid-run reset clears a nonzero result
    step_big(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    @(negedge clk); rst = 1'b1; a_big = 32'h0F0F_0F0F; b_big = 32'h0F0F_0F0F; op = 3'b001;
    @(posedge clk); #1;
    chk("R9 mid result", {32'd0, res_big}, 64'd0);
    chk("R9 mid zero", {63'd0, zero_big}, 64'd1);
    chk("R9 mid flags", {62'd0, ovf_big, cout_big}, 64'd0);
    @(negedge clk); rst = 1'b0;
    step_big(32'h0F0F_0F0F, 32'hF0F0_F0F0, 3'b001);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end
endmodule